// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller collects interrupt events from a fixed number of peripheral sources and hands one of them at a time to a CPU. Each source has an event flag, an enable, a numeric priority, a vector address in program memory, and a flag-clearing policy. The enables come in as inputs. Priority, vector and policy are fixed by parameters. A master enable input gates the whole controller.

When the master enable is high and at least one source is pending, the controller arbitrates among the pending sources. It latches the winner and raises a request with that source's vector. The CPU acknowledges the request, runs the handler, and then signals completion. No further request is issued between the acknowledge and the completion, so service is single level. Flags are cleared in one of three ways, chosen per source:
- automatically when service completes;
- by a software write of 1 to the flag bit;
- by a plain software write of the flag value, with no automatic clearing.

A flag-set event from a peripheral always wins over a clear in the same cycle.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `gie_i` is low no new request is raised. Pending sources stay latched and are requested one cycle after `gie_i` goes high.
- R2: A source is pending only when its flag and its `src_en_i` bit are both 1. Enables do not alter the flags, and `flags_o` bit i shows the flag of source i.
- R3: Among pending sources, the one with the numerically largest priority is requested.
- R4: When pending sources share the largest priority, the lowest source index is requested.
- R5: `irq_vec_o` carries the requested source's vector. The request and the vector stay unchanged until `irq_ack_i`, even if other sources become pending.
- R6: A `src_set_i` pulse sets the flag at the next clock edge, and `irq_req_o` rises at the edge after that.
- R7: `irq_ack_i` during a request drops `irq_req_o` at the next edge. No request is raised again until `irq_done_i` has been seen.
- R8: Clear mode 0 (automatic): the flag of the served source clears at the `irq_done_i` edge, and software writes have no effect on it.
- R9: Clear mode 1 (write-1-to-clear): when `sw_wr_i` is high, a 1 in `sw_wdata_i` bit i clears the flag and a 0 leaves it. `irq_done_i` does not clear it.
- R10: Clear mode 2 (manual): when `sw_wr_i` is high, flag i takes the value of `sw_wdata_i` bit i. `irq_done_i` does not clear it.
- R11: A `src_set_i` pulse in the same cycle as any clear of that flag (completion or software write) leaves the flag set.
- R12: `irq_done_i` while a request is waiting for acknowledge has no effect on the request or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gie_i | input | 1 | Master interrupt enable |
| src_en_i | input | N_SRC | Per-source enable |
| src_set_i | input | N_SRC | Per-source flag-set pulse from peripherals |
| sw_wr_i | input | 1 | Software write strobe for the flag register |
| sw_wdata_i | input | N_SRC | Software write data for the flag register |
| irq_ack_i | input | 1 | CPU accepted the request |
| irq_done_i | input | 1 | CPU returned from the handler |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | VEC_W | Vector address of the requested source |
| flags_o | output | N_SRC | Current flag state |

## Verification
Some properties are checked on every cycle:
- the arbiter's winner is pending, and no pending source outranks it;
- a request only rises after the master enable was high;
- the request and vector hold until acknowledge, and the request drops after acknowledge;
- a set pulse always leaves its flag high.

The bench scenarios cover the behaviour that depends on a sequence of cycles: the per-mode clearing at completion and on software writes, the set-versus-clear collision for each mode, and completion being ignored before acknowledge. A full sweep of flag and enable patterns shows the two-edge request latency, the priority and tie-break choices, and the vector values.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    CLR_AUTO   = 2'd0,
    CLR_W1C    = 2'd1,
    CLR_MANUAL = 2'd2
  } clr_mode_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_REQ  = 2'd1,
    HS_SERV = 2'd2
  } hs_state_e;
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  parameter logic [2*N_SRC-1:0] SRC_MODE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] set_i,
  input  logic [N_SRC-1:0] svc_clr_i,
  input  logic             sw_wr_i,
  input  logic [N_SRC-1:0] sw_wdata_i,
  output logic [N_SRC-1:0] flag_o
);
  logic [N_SRC-1:0] flag_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    localparam logic [1:0] MODE = SRC_MODE[2*i +: 2];
    logic nxt;

    always_comb begin
      nxt = flag_q[i];
      if (MODE == CLR_AUTO) begin
        if (svc_clr_i[i]) nxt = 1'b0;
      end else if (MODE == CLR_W1C) begin
        if (sw_wr_i && sw_wdata_i[i]) nxt = 1'b0;
      end else begin
        if (sw_wr_i) nxt = sw_wdata_i[i];
      end
      if (set_i[i]) nxt = 1'b1;  // event never lost
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= nxt;
    end

    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned PRIO_W = 2,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    valid_o,
  output logic [IDX_W-1:0]        idx_o
);
  logic [PRIO_W-1:0] best;

  // strict greater-than keeps the lowest index on ties
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (!valid_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end

  a_r2_winner_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pend_i[idx_o]);

  for (genvar j = 0; j < N_SRC; j++) begin : g_chk
    // R3 / R4: no pending source outranks the winner
    a_r3_r4_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && pend_i[j]) |->
        (prio_i[j*PRIO_W +: PRIO_W] < prio_i[idx_o*PRIO_W +: PRIO_W]) ||
        (prio_i[j*PRIO_W +: PRIO_W] == prio_i[idx_o*PRIO_W +: PRIO_W] &&
         IDX_W'(j) >= idx_o));
  end
endmodule

// File: rtl/irq_handshake.sv
module irq_handshake
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned VEC_W = 8,
  parameter logic [N_SRC*VEC_W-1:0] SRC_VEC = '0,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic             valid_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             ack_i,
  input  logic             done_i,
  output logic             req_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N_SRC-1:0] svc_clr_o
);
  hs_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      idx_q   <= '0;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        HS_IDLE: if (gie_i && valid_i) begin
          state_q <= HS_REQ;
          idx_q   <= idx_i;
          vec_q   <= SRC_VEC[int'(idx_i)*VEC_W +: VEC_W];
        end
        HS_REQ:  if (ack_i)  state_q <= HS_SERV;
        HS_SERV: if (done_i) state_q <= HS_IDLE;
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  always_comb begin
    svc_clr_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (state_q == HS_SERV && done_i && idx_q == IDX_W'(i)) svc_clr_o[i] = 1'b1;
  end

  assign req_o = (state_q == HS_REQ);
  assign vec_o = vec_q;

  a_r1_gie_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> $past(gie_i));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(vec_o)));
  a_r7_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i) |=> !req_o);
  a_r12_done_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (svc_clr_o == '0));
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned PRIO_W = 2,
  parameter int unsigned VEC_W  = 8,
  parameter logic [N_SRC*PRIO_W-1:0] SRC_PRIO = {2'd0, 2'd3, 2'd3, 2'd1},
  parameter logic [N_SRC*VEC_W-1:0]  SRC_VEC  = {8'h10, 8'h0C, 8'h08, 8'h04},
  parameter logic [2*N_SRC-1:0]      SRC_MODE = {CLR_AUTO, CLR_MANUAL, CLR_W1C, CLR_AUTO},
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] src_set_i,
  input  logic             sw_wr_i,
  input  logic [N_SRC-1:0] sw_wdata_i,
  input  logic             irq_ack_i,
  input  logic             irq_done_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic [N_SRC-1:0] flags_o
);
  logic [N_SRC-1:0] flag;
  logic [N_SRC-1:0] svc_clr;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;

  irq_flags #(.N_SRC(N_SRC), .SRC_MODE(SRC_MODE)) u_flags (
    .clk_i, .rst_ni,
    .set_i      (src_set_i),
    .svc_clr_i  (svc_clr),
    .sw_wr_i,
    .sw_wdata_i,
    .flag_o     (flag)
  );

  irq_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
    .clk_i, .rst_ni,
    .pend_i  (flag & src_en_i),
    .prio_i  (SRC_PRIO),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  irq_handshake #(.N_SRC(N_SRC), .VEC_W(VEC_W), .SRC_VEC(SRC_VEC)) u_hs (
    .clk_i, .rst_ni, .gie_i,
    .valid_i   (win_valid),
    .idx_i     (win_idx),
    .ack_i     (irq_ack_i),
    .done_i    (irq_done_i),
    .req_o     (irq_req_o),
    .vec_o     (irq_vec_o),
    .svc_clr_o (svc_clr)
  );

  assign flags_o = flag;
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       gie_i = 1'b0;
  logic [3:0] src_en_i = '0, src_set_i = '0, sw_wdata_i = '0;
  logic       sw_wr_i = 1'b0, irq_ack_i = 1'b0, irq_done_i = 1'b0;
  logic       irq_req_o;
  logic [7:0] irq_vec_o;
  logic [3:0] flags_o;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  prio_irq_ctrl u0 (.*);

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // bench priority table: src0=1, src1=3, src2=3, src3=0; vector=(i+1)*4
  function automatic int prio_of(int i);
    return (i == 0) ? 1 : (i == 3) ? 0 : 3;
  endfunction

  function automatic int winner(logic [3:0] pend);
    int w = -1;
    for (int i = 0; i < 4; i++)
      if (pend[i] && (w < 0 || prio_of(i) > prio_of(w))) w = i;
    return w;
  endfunction

  task automatic serve();
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    irq_done_i = 1'b1; tick(); irq_done_i = 1'b0;
  endtask

  initial begin
    #(20ns * 20000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rst_ni = 1'b1; src_en_i = 4'hF;
    tick();
    chk(irq_req_o == 0, "reset req", irq_req_o, 0);
    chk(flags_o == 0, "reset flags", flags_o, 0);

    // R1: gie low blocks
    src_set_i = 4'b0001; tick(); src_set_i = 0;
    tick(); tick(); tick();
    chk(irq_req_o == 0, "R1 gie low", irq_req_o, 0);
    gie_i = 1'b1; tick();
    chk(irq_req_o == 1, "R1 gie high", irq_req_o, 1);
    chk(irq_vec_o == 8'h04, "R5 vector src0", irq_vec_o, 8'h04);
    // R5: higher source arrives, request held
    src_set_i = 4'b0010; tick(); src_set_i = 0; tick();
    chk(irq_req_o == 1 && irq_vec_o == 8'h04, "R5 held", irq_vec_o, 8'h04);
    // R12: done before ack ignored
    irq_done_i = 1'b1; tick(); irq_done_i = 1'b0;
    chk(irq_req_o == 1, "R12 req kept", irq_req_o, 1);
    chk(flags_o == 4'b0011, "R12 flags kept", flags_o, 4'b0011);
    // R7
    irq_ack_i = 1'b1; tick(); irq_ack_i = 1'b0;
    chk(irq_req_o == 0, "R7 ack drops", irq_req_o, 0);
    tick(); tick();
    chk(irq_req_o == 0, "R7 no nesting", irq_req_o, 0);
    // R11: set collides with auto clear on src0
    irq_done_i = 1'b1; src_set_i = 4'b0001; tick(); irq_done_i = 0; src_set_i = 0;
    chk(flags_o == 4'b0011, "R11 set vs done", flags_o, 4'b0011);
    tick();
    chk(irq_req_o == 1 && irq_vec_o == 8'h08, "R3 prio wins", irq_vec_o, 8'h08);
    serve();
    chk(flags_o == 4'b0011, "R9 done keeps w1c", flags_o, 4'b0011);
    sw_wr_i = 1'b1; sw_wdata_i = 4'b0000; tick(); sw_wr_i = 0;
    chk(flags_o == 4'b0011, "R9 write 0 keeps", flags_o, 4'b0011);
    sw_wr_i = 1'b1; sw_wdata_i = 4'b0011; tick(); sw_wr_i = 0;
    chk(flags_o == 4'b0001, "R9 w1c / R8 auto ignores write", flags_o, 4'b0001);
    chk(irq_req_o == 1 && irq_vec_o == 8'h08, "R5 latched", irq_vec_o, 8'h08);
    serve();
    chk(flags_o == 4'b0001, "R9 no clear on done", flags_o, 4'b0001);
    tick();
    chk(irq_req_o == 1 && irq_vec_o == 8'h04, "R3 next src0", irq_vec_o, 8'h04);
    serve();
    chk(flags_o == 4'b0000, "R8 auto clear", flags_o, 4'b0000);
    tick();
    chk(irq_req_o == 0, "R2 none pending", irq_req_o, 0);

    // R4 tie between src1 and src2
    src_set_i = 4'b0110; tick(); src_set_i = 0; tick();
    chk(irq_req_o == 1 && irq_vec_o == 8'h08, "R4 tie low index", irq_vec_o, 8'h08);
    serve();
    chk(flags_o == 4'b0110, "R10 done keeps manual", flags_o, 4'b0110);
    sw_wr_i = 1'b1; sw_wdata_i = 4'b0010; tick(); sw_wr_i = 0;
    chk(flags_o == 4'b0000, "R10 write 0 clears", flags_o, 4'b0000);
    sw_wr_i = 1'b1; sw_wdata_i = 4'b0100; tick(); sw_wr_i = 0;
    chk(flags_o == 4'b0100, "R10 write 1 sets", flags_o, 4'b0100);
    serve(); tick();
    chk(irq_req_o == 1 && irq_vec_o == 8'h0C, "R3 src2", irq_vec_o, 8'h0C);
    src_set_i = 4'b0010; sw_wr_i = 1'b1; sw_wdata_i = 4'b0010; tick();
    src_set_i = 0; sw_wr_i = 0;
    chk(flags_o == 4'b0010, "R11 set vs w1c", flags_o, 4'b0010);
    src_set_i = 4'b0100; sw_wr_i = 1'b1; sw_wdata_i = 4'b0000; tick();
    src_set_i = 0; sw_wr_i = 0;
    chk(flags_o == 4'b0110, "R11 set vs manual", flags_o, 4'b0110);

    // R2/R3/R4/R6 sweep over flag and enable patterns
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        int w;
        rst_ni = 1'b0; tick(); rst_ni = 1'b1;
        src_en_i = 4'(e); src_set_i = 4'(f); tick(); src_set_i = 0;
        chk(irq_req_o == 0, "R6 one edge", irq_req_o, 0);
        chk(flags_o == 4'(f), "R2 flags", flags_o, f);
        tick();
        w = winner(4'(f & e));
        if (w < 0) chk(irq_req_o == 0, "R2 not pending", irq_req_o, 0);
        else chk(irq_req_o == 1 && irq_vec_o == 8'((w + 1) * 4),
                 "R6 R3 R4 sweep", irq_vec_o, (w + 1) * 4);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule